// File: doc/BRIEF.md
# Reserved-Aware Resource Element Mapper

This block sequences the transfer of a dense stream of modulated symbols into a slot resource grid, or back out of it. A pass covers a contiguous range of OFDM symbols and, inside each symbol, the physical resource blocks (PRBs) that the grant enables. Each PRB spans twelve subcarriers. Positions flagged in a per-symbol reserved mask, such as reference-signal or configured reserved elements, are stepped over, so the stream side sees no holes.

The block carries no sample data. For each usable subcarrier it drives a grid address and a pair of strobes: one on the grid side and one on the stream side. The direction is set by a mode input. In put mode the stream is read and the grid is written. In get mode the grid is read and the stream is written. A running element count serves as the stream index during the pass and holds the total once the pass ends, so it can be compared with the expected number of elements. The reserved mask is not generated here. The block shows which symbol it is walking, and the surrounding logic returns the mask of that symbol in the same cycle.

Top module: `re_grid_mapper`

## Requirements
- R1: A `start` pulse while idle captures `modeGet`, `nofPrb`, `startSym`, `numSym` and `grantMask` and begins a pass in the next cycle. A `start` while `busy` is ignored, and changing these inputs during a pass does not alter it.
- R2: Symbols are walked in ascending order from `startSym` to `startSym+numSym-1` inclusive. `maskSym` shows the symbol being walked, and `rsvdMask` bit `rb*12+sc` is taken as the reserved flag of subcarrier `sc` of PRB `rb` in that symbol.
- R3: Within a symbol, PRBs 0 to `nofPrb-1` are visited in ascending order. A PRB whose `grantMask` bit is 0 takes exactly one cycle and raises no strobe. A granted PRB takes twelve cycles, one per subcarrier in ascending order.
- R4: The grid address of subcarrier `sc` of PRB `rb` in symbol `l` is `(nofPrb*l + rb)*12 + sc`.
- R5: A reserved subcarrier raises no strobe and leaves `elemCount` unchanged. The stream index therefore advances only on transferred elements and has no gaps.
- R6: With `modeGet`=0 (put), a transfer raises `gridWe` and `streamRd` together. With `modeGet`=1 (get), it raises `gridRe` and `streamWr` together. Only one direction is active at a time.
- R7: `elemCount` is cleared when a pass starts. During a transfer cycle it shows the stream index of that element, and it increases by one after each transfer. After the pass it holds the total until the next start.
- R8: `done` is high for exactly one cycle, the cycle after the last visited subcarrier or PRB, with `busy` low. A pass therefore lasts `numSym * sum(granted ? 12 : 1)` cycles.
- R9: After reset the block is idle: `busy`, `done`, all strobes and `elemCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only while idle |
| modeGet | input | 1 | 0 = put (stream to grid), 1 = get (grid to stream) |
| nofPrb | input | PRB_W | Carrier width in PRBs, 1 to MAX_PRB |
| startSym | input | SYM_W | First OFDM symbol of the pass |
| numSym | input | SYM_W | Number of symbols, at least 1 |
| grantMask | input | MAX_PRB | Per-PRB grant enable |
| rsvdMask | input | MAX_PRB*12 | Reserved flags of the symbol shown on maskSym |
| maskSym | output | SYM_W | Symbol whose mask must be on rsvdMask |
| gridAddr | output | ADDR_W | Grid element address |
| gridWe | output | 1 | Grid write strobe (put) |
| gridRe | output | 1 | Grid read strobe (get) |
| streamRd | output | 1 | Stream read strobe (put) |
| streamWr | output | 1 | Stream write strobe (get) |
| elemCount | output | CNT_W | Stream index during the pass, total afterwards |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The mapper is driven with grants that are full, sparse, alternating and empty, and with masks that are clear, that reserve every other subcarrier on one symbol, that reserve whole symbols, or that follow an irregular pattern. Full grants without a mask isolate the address formula and the walk order. Sparse grants separate a one-cycle skip from a twelve-cycle walk. Whole-symbol and irregular masks show whether the stream index advances only on transfers. Both modes, a pass ending at the highest grid address, a start issued mid-pass with altered inputs, and back-to-back passes show whether the configuration is captured once and the strobes follow the mode.

// File: rtl/re_map_pkg.sv
package re_map_pkg;
  localparam int SC_PER_PRB = 12;

  typedef struct packed {
    logic clear;   // pass accepted: reset the element count
    logic visit;   // a subcarrier or skipped PRB is being visited
    logic prbOn;   // the visited PRB is granted
  } strobe_t;
endpackage

// File: rtl/re_map_ctrl.sv
module re_map_ctrl
  import re_map_pkg::*;
#(
  parameter int MAX_PRB = 8,
  parameter int SYM_W   = 4,
  parameter int PRB_W   = 4,
  parameter int RB_W    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             modeGet,
  input  logic [PRB_W-1:0] nofPrb,
  input  logic [SYM_W-1:0] startSym,
  input  logic [SYM_W-1:0] numSym,
  input  logic [MAX_PRB-1:0] grantMask,
  output strobe_t          stb,
  output logic [SYM_W-1:0] curSym,
  output logic [RB_W-1:0]  curRb,
  output logic [3:0]       curSc,
  output logic [PRB_W-1:0] nPrbQ,
  output logic             modeQ,
  output logic             busy,
  output logic             done
);
  typedef enum logic {IDLE, RUN} state_t;
  state_t stateQ;

  logic [SYM_W:0]     symQ, endSymQ;
  logic [MAX_PRB-1:0] grantQ;
  logic               doneQ;
  logic               lastSc, lastRb, lastSym, prbOn;

  assign prbOn   = grantQ[curRb];
  assign lastSc  = !prbOn || (curSc == 4'(SC_PER_PRB - 1));
  assign lastRb  = (PRB_W'(curRb) == nPrbQ - PRB_W'(1));
  assign lastSym = (symQ == endSymQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= IDLE;
      symQ    <= '0;
      endSymQ <= '0;
      curRb   <= '0;
      curSc   <= '0;
      nPrbQ   <= '0;
      grantQ  <= '0;
      modeQ   <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (stateQ)
        IDLE: if (start) begin
          stateQ  <= RUN;
          symQ    <= {1'b0, startSym};
          endSymQ <= {1'b0, startSym} + {1'b0, numSym} - (SYM_W+1)'(1);
          curRb   <= '0;
          curSc   <= '0;
          nPrbQ   <= nofPrb;
          grantQ  <= grantMask;
          modeQ   <= modeGet;
        end
        RUN: begin
          if (!lastSc) begin
            curSc <= curSc + 4'd1;
          end else begin
            curSc <= '0;
            if (!lastRb) begin
              curRb <= curRb + RB_W'(1);
            end else begin
              curRb <= '0;
              if (lastSym) begin
                stateQ <= IDLE;
                doneQ  <= 1'b1;
              end else begin
                symQ <= symQ + (SYM_W+1)'(1);
              end
            end
          end
        end
        default: stateQ <= IDLE;
      endcase
    end
  end

  assign curSym    = symQ[SYM_W-1:0];
  assign busy      = (stateQ == RUN);
  assign done      = doneQ;
  assign stb.clear = start && (stateQ == IDLE);
  assign stb.visit = (stateQ == RUN);
  assign stb.prbOn = prbOn;
endmodule

// File: rtl/re_map_dp.sv
module re_map_dp
  import re_map_pkg::*;
#(
  parameter int MAX_PRB = 8,
  parameter int SYM_W   = 4,
  parameter int PRB_W   = 4,
  parameter int RB_W    = 3,
  parameter int ADDR_W  = 11,
  parameter int CNT_W   = 11,
  parameter int MASK_W  = 96,
  parameter int MIDX_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SYM_W-1:0]  curSym,
  input  logic [RB_W-1:0]   curRb,
  input  logic [3:0]        curSc,
  input  logic [PRB_W-1:0]  nPrbQ,
  input  logic              modeQ,
  input  logic [MASK_W-1:0] rsvdMask,
  output logic [ADDR_W-1:0] gridAddr,
  output logic              gridWe,
  output logic              gridRe,
  output logic              streamRd,
  output logic              streamWr,
  output logic [CNT_W-1:0]  elemCount
);
  logic [MIDX_W-1:0] maskIdx;
  logic [ADDR_W-1:0] prbIdx;
  logic              xfer;
  logic [CNT_W-1:0]  cntQ;

  // Flat PRB position in the grid, then the subcarrier offset
  assign prbIdx   = ADDR_W'(nPrbQ) * ADDR_W'(curSym) + ADDR_W'(curRb);
  assign gridAddr = prbIdx * ADDR_W'(SC_PER_PRB) + ADDR_W'(curSc);

  assign maskIdx  = MIDX_W'(curRb) * MIDX_W'(SC_PER_PRB) + MIDX_W'(curSc);
  assign xfer     = stb.visit && stb.prbOn && !rsvdMask[maskIdx];

  assign gridWe   = xfer && !modeQ;
  assign streamRd = xfer && !modeQ;
  assign gridRe   = xfer && modeQ;
  assign streamWr = xfer && modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cntQ <= '0;
    else if (stb.clear) cntQ <= '0;
    else if (xfer)      cntQ <= cntQ + CNT_W'(1);
  end

  assign elemCount = cntQ;
endmodule

// File: rtl/re_grid_mapper.sv
module re_grid_mapper
  import re_map_pkg::*;
#(
  parameter int MAX_PRB  = 8,
  parameter int NUM_SYMB = 14,
  localparam int SYM_W   = $clog2(NUM_SYMB),
  localparam int PRB_W   = $clog2(MAX_PRB + 1),
  localparam int RB_W    = (MAX_PRB > 1) ? $clog2(MAX_PRB) : 1,
  localparam int MASK_W  = MAX_PRB * SC_PER_PRB,
  localparam int MIDX_W  = $clog2(MASK_W),
  localparam int GRID_N  = MASK_W * NUM_SYMB,
  localparam int ADDR_W  = $clog2(GRID_N),
  localparam int CNT_W   = $clog2(GRID_N + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               modeGet,
  input  logic [PRB_W-1:0]   nofPrb,
  input  logic [SYM_W-1:0]   startSym,
  input  logic [SYM_W-1:0]   numSym,
  input  logic [MAX_PRB-1:0] grantMask,
  input  logic [MASK_W-1:0]  rsvdMask,
  output logic [SYM_W-1:0]   maskSym,
  output logic [ADDR_W-1:0]  gridAddr,
  output logic               gridWe,
  output logic               gridRe,
  output logic               streamRd,
  output logic               streamWr,
  output logic [CNT_W-1:0]   elemCount,
  output logic               busy,
  output logic               done
);
  strobe_t          stb;
  logic [SYM_W-1:0] curSym;
  logic [RB_W-1:0]  curRb;
  logic [3:0]       curSc;
  logic [PRB_W-1:0] nPrbQ;
  logic             modeQ;

  re_map_ctrl #(
    .MAX_PRB(MAX_PRB), .SYM_W(SYM_W), .PRB_W(PRB_W), .RB_W(RB_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .modeGet(modeGet),
    .nofPrb(nofPrb), .startSym(startSym), .numSym(numSym),
    .grantMask(grantMask), .stb(stb), .curSym(curSym), .curRb(curRb),
    .curSc(curSc), .nPrbQ(nPrbQ), .modeQ(modeQ), .busy(busy), .done(done)
  );

  re_map_dp #(
    .MAX_PRB(MAX_PRB), .SYM_W(SYM_W), .PRB_W(PRB_W), .RB_W(RB_W),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MASK_W(MASK_W), .MIDX_W(MIDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .curSym(curSym), .curRb(curRb),
    .curSc(curSc), .nPrbQ(nPrbQ), .modeQ(modeQ), .rsvdMask(rsvdMask),
    .gridAddr(gridAddr), .gridWe(gridWe), .gridRe(gridRe),
    .streamRd(streamRd), .streamWr(streamWr), .elemCount(elemCount)
  );

  assign maskSym = curSym;
endmodule

// File: rtl/re_grid_mapper_chk.sv
module re_grid_mapper_chk #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              gridWe,
  input logic              gridRe,
  input logic              streamRd,
  input logic              streamWr,
  input logic [ADDR_W-1:0] gridAddr,
  input logic [CNT_W-1:0]  elemCount
);
  logic              xfer;
  logic              havePrev;
  logic [ADDR_W-1:0] prevAddr;

  assign xfer = gridWe || gridRe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      havePrev <= 1'b0;
      prevAddr <= '0;
    end else if (start && !busy) begin
      havePrev <= 1'b0;
    end else if (xfer) begin
      havePrev <= 1'b1;
      prevAddr <= gridAddr;
    end
  end

  // R3: transfers within one pass move strictly upward through the grid
  assert_addr_ascend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (xfer && havePrev) |-> (gridAddr > prevAddr));

  // R7: every transfer advances the stream index by one
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    xfer |=> (elemCount == $past(elemCount) + CNT_W'(1)));

  // R5: visits without a transfer leave the stream index alone
  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xfer) |=> $stable(elemCount));

  // R8: done is a single-cycle pulse and arrives with the block idle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: no strobe while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(gridWe || gridRe || streamRd || streamWr));
endmodule

bind re_grid_mapper re_grid_mapper_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .gridWe(gridWe), .gridRe(gridRe), .streamRd(streamRd), .streamWr(streamWr),
  .gridAddr(gridAddr), .elemCount(elemCount)
);

// File: tb/re_grid_mapper_tb_top.sv
module re_grid_mapper_tb_top;
  localparam int MAX_PRB = 8;
  localparam int MASK_W  = MAX_PRB * 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              modeGet = 1'b0;
  logic [3:0]        nofPrb = 4'd1;
  logic [3:0]        startSym = '0;
  logic [3:0]        numSym = 4'd1;
  logic [7:0]        grantMask = '0;
  logic [MASK_W-1:0] rsvdMask;
  logic [3:0]        maskSym;
  logic [10:0]       gridAddr;
  logic              gridWe, gridRe, streamRd, streamWr, busy, done;
  logic [10:0]       elemCount;

  int checks = 0;
  int errors = 0;
  int curPat = 0;

  always #5 clk = ~clk;

  re_grid_mapper dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeGet(modeGet), .nofPrb(nofPrb),
    .startSym(startSym), .numSym(numSym), .grantMask(grantMask),
    .rsvdMask(rsvdMask), .maskSym(maskSym), .gridAddr(gridAddr),
    .gridWe(gridWe), .gridRe(gridRe), .streamRd(streamRd), .streamWr(streamWr),
    .elemCount(elemCount), .busy(busy), .done(done)
  );

  // Reserved pattern: 1 = even subcarriers of symbol 3, 2 = all of even symbols,
  // 3 = irregular pattern, 0 = nothing reserved
  function automatic logic maskBit(int pat, int sym, int k);
    case (pat)
      1: return (sym == 3) && ((k % 12) % 2 == 0);
      2: return (sym % 2) == 0;
      3: return ((sym * 7 + k * 3) % 5) == 0;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int k = 0; k < MASK_W; k++) rsvdMask[k] = maskBit(curPat, int'(maskSym), k);
  end

  typedef struct packed {
    logic       mode;
    logic [3:0] prb;
    logic [3:0] s;
    logic [3:0] l;
    logic [7:0] grant;
    logic [1:0] pat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 4'd4, 4'd0,  4'd2,  8'h0F, 2'd0},
    '{1'b1, 4'd3, 4'd2,  4'd3,  8'h05, 2'd1},
    '{1'b0, 4'd8, 4'd10, 4'd4,  8'hA5, 2'd3},
    '{1'b1, 4'd1, 4'd12, 4'd2,  8'h01, 2'd2},
    '{1'b0, 4'd5, 4'd0,  4'd14, 8'h1F, 2'd1},
    '{1'b1, 4'd6, 4'd4,  4'd2,  8'h00, 2'd0}
  };

  int  visitIdx;
  int  expIdx;
  bit  seqBad;
  bit  glitchOn;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One visited cycle: compare at this falling edge, then move to the next one
  task automatic visit(input vec_t v, input int sym, input bit exp, input int addr);
    bit ok;
    ok = busy && !done && (int'(maskSym) == sym);
    if (exp) begin
      ok = ok && (int'(gridAddr) == addr) && (int'(elemCount) == expIdx) &&
           (gridWe == !v.mode) && (streamRd == !v.mode) &&
           (gridRe == v.mode) && (streamWr == v.mode);
    end else begin
      ok = ok && !gridWe && !gridRe && !streamRd && !streamWr;
    end
    if (!ok && !seqBad) begin
      seqBad = 1'b1;
      $display("FAIL R2/R3/R4/R5/R6 visit %0d sym %0d: actual addr=%0d idx=%0d we=%0b re=%0b rd=%0b wr=%0b msym=%0d busy=%0b expected xfer=%0b addr=%0d idx=%0d",
               visitIdx, sym, gridAddr, elemCount, gridWe, gridRe, streamRd, streamWr,
               maskSym, busy, exp, addr, expIdx);
    end
    if (exp) expIdx++;
    if (glitchOn && visitIdx == 3) begin
      start = 1'b1; nofPrb = 4'd1; grantMask = 8'h00; modeGet = !v.mode; numSym = 4'd1;
    end else begin
      start = 1'b0;
    end
    visitIdx++;
    @(negedge clk);
  endtask

  task automatic runPass(input vec_t v, input bit glitch, input string tag);
    curPat = int'(v.pat);
    modeGet = v.mode; nofPrb = v.prb; startSym = v.s; numSym = v.l; grantMask = v.grant;
    start = 1'b1;
    visitIdx = 0; expIdx = 0; seqBad = 1'b0; glitchOn = glitch;
    @(negedge clk);
    start = 1'b0;
    for (int s = int'(v.s); s < int'(v.s) + int'(v.l); s++) begin
      for (int rb = 0; rb < int'(v.prb); rb++) begin
        if (!v.grant[rb]) visit(v, s, 1'b0, 0);
        else for (int sc = 0; sc < 12; sc++)
          visit(v, s, !maskBit(int'(v.pat), s, rb * 12 + sc),
                (int'(v.prb) * s + rb) * 12 + sc);
      end
    end
    start = 1'b0;
    check(!seqBad, {tag, " R2 R3 R4 R5 R6 walk sequence"}, int'(seqBad), 0);
    check(done && !busy, {tag, " R8 done in cycle after last visit"}, int'({done, busy}), 2);
    check(int'(elemCount) == expIdx, {tag, " R7 total element count"}, int'(elemCount), expIdx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: idle after reset
    check(!busy && !done && !gridWe && !gridRe && !streamRd && !streamWr && elemCount == 0,
          "R9 reset state", int'({busy, done, gridWe, gridRe, streamRd, streamWr}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && elemCount == 0, "R9 idle after reset release", int'(busy), 0);

    // Table of passes, back to back (start in the done cycle)
    for (int i = 0; i < 6; i++) runPass(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R7: total holds after the pass
    @(negedge clk);
    check(!done, "R8 done drops after one cycle", int'(done), 0);
    repeat (3) @(negedge clk);
    check(elemCount == 0, "R7 count held after empty-grant pass", int'(elemCount), 0);

    // R1: start mid-pass with altered inputs is ignored
    runPass('{1'b0, 4'd3, 4'd5, 4'd2, 8'h07, 2'd3}, 1'b1, "glitch R1");

    // R4: pass ending at the highest grid address
    runPass('{1'b1, 4'd8, 4'd13, 4'd1, 8'h80, 2'd0}, 1'b0, "maxaddr R4");
    repeat (2) @(negedge clk);
    check(elemCount == 11'd12, "R7 count held after pass", int'(elemCount), 12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule